// File: doc/BRIEF.md
# Segmented Block-Write Packet Receiver

This block handles the data phase that follows an accepted block-write command on a byte-oriented serial link. The command decoder hands it a start address, a total byte count and a flag that says whether each packet carries a trailing checksum. The block then follows the incoming byte stream. It checks each packet's header byte, forwards payload bytes one at a time to a memory write port at incrementing addresses, and discards checksum bytes. It raises a one-cycle completion pulse once the commanded number of bytes has arrived. No response bytes are produced.

A transfer is split into packets of at most `PKT_BYTES` payload bytes, and only the last packet may be shorter. Every packet opens with a header byte whose upper nibble is 0xF and whose lower nibble is an order code. The code says whether the packet is the first of several, a middle one, or the last or only one. The block works out which code it expects from the bytes still outstanding. A wrong header, or the chip select dropping while a transfer is open, raises a one-cycle error pulse and abandons the transfer.

The control FSM has five states. `ST_IDLE` waits for a start. `ST_HEADER` expects a header byte. `ST_DATA` forwards payload. `ST_CRC_A` and `ST_CRC_B` swallow the two checksum bytes. The transitions are:
- ST_IDLE to ST_HEADER on a start whose size is accepted.
- ST_HEADER to ST_DATA on a good header.
- ST_DATA to ST_CRC_A at the end of a packet when the checksum is on.
- ST_DATA to ST_HEADER at the end of a packet that is not the last, when the checksum is off.
- ST_CRC_A to ST_CRC_B on the first checksum byte.
- ST_CRC_B to ST_HEADER when bytes are still outstanding.
- To ST_IDLE, with done, after the final payload byte (checksum off) or after the final checksum byte (checksum on).
- To ST_IDLE, with err, on a bad header or a chip-select drop.

Top module: `blkwr_pkt_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_en`, `done` and `err` are low and the block is idle.
- R2: A start whose `cmd_size` is below 5 is rejected. `err` pulses in the next cycle, no byte is written, and the block stays idle.
- R3: A header byte is accepted only if bits [7:4] are 4'hF and bits [3:0] equal the expected order code. The expected code is 3 when the outstanding byte count is at most `PKT_BYTES`. Otherwise it is 1 for the first packet of the transfer and 2 for any later packet. Any other header pulses `err` one cycle later and returns the block to idle.
- R4: Each payload byte accepted in the data phase gives `wr_en` high for one cycle, one cycle later. `wr_data` equals that byte, and `wr_addr` equals `cmd_addr` plus the byte's offset within the transfer, modulo 2^ADDR_W.
- R5: A packet carries min(outstanding bytes, `PKT_BYTES`) payload bytes. The byte after it is a header, or the first checksum byte when the checksum is on.
- R6: `cmd_crc_en` is captured at start. When it is set, exactly two bytes follow each packet's payload. They are consumed, never written, and their values have no effect.
- R7: `done` pulses for one cycle, one cycle after the final byte of the transfer. That byte is the last payload byte with the checksum off, or the second checksum byte with it on.
- R8: If `cs_active` is low in any cycle while a transfer is open, `err` pulses in the next cycle. The transfer is abandoned, and later bytes produce no writes until a new start.
- R9: Cycles with `rx_valid` low make no progress, and a `cmd_start` while a transfer is open is ignored.
- R10: After `done` or `err` the block is idle, and a new start is accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that opens a block-write data phase |
| cmd_addr | input | ADDR_W | Destination address of the first payload byte |
| cmd_size | input | SIZE_W | Total payload bytes in the transfer |
| cmd_crc_en | input | 1 | Packets carry two trailing checksum bytes |
| cs_active | input | 1 | Chip select asserted (high = selected) |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte from the serial shifter |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 8 | Memory write data |
| done | output | 1 | One-cycle pulse when the transfer is complete |
| err | output | 1 | One-cycle pulse when a transfer is rejected or aborted |

## Verification
Some behaviours are checked on every cycle by the assertions:
- rejection of a short size;
- an error one cycle after a header whose tag nibble is wrong;
- an abort after a chip-select drop;
- a stall when no byte is present;
- packet lengths staying within `PKT_BYTES`;
- completion happening only once the outstanding count reaches zero.

Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural model every clock:
- the choice of the expected order code across first, middle and final packets;
- the exact cycle of `done` with and without checksum bytes;
- the address sequence, including its wrap;
- the proof that discarded checksum bytes and bytes after an abort never reach memory.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_DATA,
        ST_CRC_A,
        ST_CRC_B
    } blkwr_state_e;

    localparam logic [3:0] HDR_TAG        = 4'hF;
    localparam logic [3:0] ORD_OPEN       = 4'd1;
    localparam logic [3:0] ORD_MIDDLE     = 4'd2;
    localparam logic [3:0] ORD_CLOSE      = 4'd3;
    localparam int         MIN_BLOCK_BYTES = 5;

endpackage

// File: rtl/blkwr_hdr_check.sv
module blkwr_hdr_check #(
    parameter int SIZE_W    = 24,
    parameter int PKT_BYTES = 8192
) (
    input  logic [7:0]        hdr_byte,
    input  logic [SIZE_W-1:0] remaining,
    input  logic              first_pkt,
    output logic              hdr_ok
);
    import blkwr_pkg::*;

    localparam logic [SIZE_W-1:0] PKT_LIMIT = SIZE_W'(PKT_BYTES);

    logic [3:0] want_order;

    always_comb begin
        if (remaining <= PKT_LIMIT) begin
            want_order = ORD_CLOSE;
        end else if (first_pkt) begin
            want_order = ORD_OPEN;
        end else begin
            want_order = ORD_MIDDLE;
        end
        hdr_ok = (hdr_byte[7:4] == HDR_TAG) && (hdr_byte[3:0] == want_order);
    end

endmodule

// File: rtl/blkwr_len_track.sv
module blkwr_len_track #(
    parameter int ADDR_W    = 24,
    parameter int SIZE_W    = 24,
    parameter int PKT_BYTES = 8192,
    localparam int PKT_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              open_pkt,
    input  logic              take_byte,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    output logic [SIZE_W-1:0] remaining,
    output logic [PKT_W-1:0]  pkt_left,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              first_pkt
);
    localparam logic [SIZE_W-1:0] PKT_LIMIT = SIZE_W'(PKT_BYTES);
    localparam logic [PKT_W-1:0]  PKT_FULL  = PKT_W'(PKT_BYTES);
    localparam logic [SIZE_W-1:0] ONE_S     = SIZE_W'(1);
    localparam logic [PKT_W-1:0]  ONE_P     = PKT_W'(1);
    localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
            pkt_left  <= '0;
            cur_addr  <= '0;
            first_pkt <= 1'b0;
        end else if (load) begin
            remaining <= ld_size;
            pkt_left  <= '0;
            cur_addr  <= ld_addr;
            first_pkt <= 1'b1;
        end else if (open_pkt) begin
            pkt_left  <= (remaining <= PKT_LIMIT) ? PKT_W'(remaining) : PKT_FULL;
            first_pkt <= 1'b0;
        end else if (take_byte) begin
            remaining <= remaining - ONE_S;
            pkt_left  <= pkt_left - ONE_P;
            cur_addr  <= cur_addr + ONE_A;
        end
    end

    AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_left <= PKT_FULL);  // R5

    AST_PKT_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && !load && !open_pkt) |=> (pkt_left == $past(pkt_left) - ONE_P));  // R5

endmodule

// File: rtl/blkwr_pkt_rx.sv
module blkwr_pkt_rx #(
    parameter int ADDR_W    = 24,
    parameter int SIZE_W    = 24,
    parameter int PKT_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              cmd_crc_en,
    input  logic              cs_active,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              err
);
    import blkwr_pkg::*;

    localparam int PKT_W = $clog2(PKT_BYTES + 1);
    localparam logic [SIZE_W-1:0] MIN_SZ = SIZE_W'(MIN_BLOCK_BYTES);
    localparam logic [SIZE_W-1:0] ONE_S  = SIZE_W'(1);
    localparam logic [PKT_W-1:0]  ONE_P  = PKT_W'(1);

    blkwr_state_e state, nxt_state;

    logic              crc_q;
    logic              do_load, do_open, do_take, do_fin, do_fail;
    logic              hdr_ok;
    logic [SIZE_W-1:0] remaining;
    logic [PKT_W-1:0]  pkt_left;
    logic [ADDR_W-1:0] cur_addr;
    logic              first_pkt;

    blkwr_len_track #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .PKT_BYTES(PKT_BYTES)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .open_pkt (do_open),
        .take_byte(do_take),
        .ld_addr  (cmd_addr),
        .ld_size  (cmd_size),
        .remaining(remaining),
        .pkt_left (pkt_left),
        .cur_addr (cur_addr),
        .first_pkt(first_pkt)
    );

    blkwr_hdr_check #(
        .SIZE_W   (SIZE_W),
        .PKT_BYTES(PKT_BYTES)
    ) u_hdr (
        .hdr_byte (rx_byte),
        .remaining(remaining),
        .first_pkt(first_pkt),
        .hdr_ok   (hdr_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            crc_q <= 1'b0;
        end else begin
            state <= nxt_state;
            if (do_load) begin
                crc_q <= cmd_crc_en;
            end
        end
    end

    // Next state and control strobes
    always_comb begin
        nxt_state = state;
        do_load   = 1'b0;
        do_open   = 1'b0;
        do_take   = 1'b0;
        do_fin    = 1'b0;
        do_fail   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_start) begin
                    if (cmd_size < MIN_SZ) begin
                        do_fail = 1'b1;
                    end else begin
                        do_load   = 1'b1;
                        nxt_state = ST_HEADER;
                    end
                end
            end
            ST_HEADER: begin
                if (!cs_active) begin
                    do_fail   = 1'b1;
                    nxt_state = ST_IDLE;
                end else if (rx_valid) begin
                    if (hdr_ok) begin
                        do_open   = 1'b1;
                        nxt_state = ST_DATA;
                    end else begin
                        do_fail   = 1'b1;
                        nxt_state = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (!cs_active) begin
                    do_fail   = 1'b1;
                    nxt_state = ST_IDLE;
                end else if (rx_valid) begin
                    do_take = 1'b1;
                    if (pkt_left == ONE_P) begin
                        if (crc_q) begin
                            nxt_state = ST_CRC_A;
                        end else if (remaining == ONE_S) begin
                            do_fin    = 1'b1;
                            nxt_state = ST_IDLE;
                        end else begin
                            nxt_state = ST_HEADER;
                        end
                    end
                end
            end
            ST_CRC_A: begin
                if (!cs_active) begin
                    do_fail   = 1'b1;
                    nxt_state = ST_IDLE;
                end else if (rx_valid) begin
                    nxt_state = ST_CRC_B;
                end
            end
            ST_CRC_B: begin
                if (!cs_active) begin
                    do_fail   = 1'b1;
                    nxt_state = ST_IDLE;
                end else if (rx_valid) begin
                    if (remaining == '0) begin
                        do_fin    = 1'b1;
                        nxt_state = ST_IDLE;
                    end else begin
                        nxt_state = ST_HEADER;
                    end
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            wr_en <= do_take;
            done  <= do_fin;
            err   <= do_fail;
            if (do_take) begin
                wr_addr <= cur_addr;
                wr_data <= rx_byte;
            end
        end
    end

    AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_start && cmd_size < MIN_SZ) |=> (err && !wr_en && state == ST_IDLE));  // R2

    AST_BAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEADER && cs_active && rx_valid && rx_byte[7:4] != HDR_TAG) |=> err);  // R3

    AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state == ST_DATA));  // R4

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remaining == '0 && state == ST_IDLE));  // R7

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !cs_active) |=> (err && state == ST_IDLE));  // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cs_active && !rx_valid) |=> ($stable(state) && !wr_en));  // R9

    AST_DATA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (pkt_left != '0));  // R5

endmodule

// File: tb/test_blkwr_pkt_rx.sv
module test_blkwr_pkt_rx;
    localparam int AW  = 24;
    localparam int SW  = 24;
    localparam int PKT = 8;
    localparam longint AMASK = (longint'(1) << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [SW-1:0] cmd_size = '0;
    logic          cmd_crc_en = 1'b0;
    logic          cs_active = 1'b1;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          wr_en, done, err;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    blkwr_pkt_rx #(.ADDR_W(AW), .SIZE_W(SW), .PKT_BYTES(PKT)) i_blkwr_pkt_rx (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .cmd_crc_en(cmd_crc_en), .cs_active(cs_active),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .err(err)
    );

    initial forever #5 clk = ~clk;

    // Behavioural reference model
    int     m_phase = 0;    // 0 idle, 1 header, 2 payload, 3 checksum skip
    longint m_rem, m_off, m_base;
    int     m_inpkt, m_skip;
    bit     m_crc, m_first;
    bit     exp_wr = 0, exp_done = 0, exp_err = 0;
    longint exp_addr = 0;
    int     exp_data = 0;
    bit     model_live = 0;

    always @(posedge clk) begin
        int want;
        exp_wr = 0; exp_done = 0; exp_err = 0;
        model_live = 1;
        if (!rst_n) begin
            m_phase = 0;
        end else if (m_phase == 0) begin
            if (cmd_start) begin
                if (cmd_size < 5) exp_err = 1;
                else begin
                    m_rem = cmd_size; m_off = 0; m_base = cmd_addr;
                    m_crc = cmd_crc_en; m_first = 1; m_phase = 1;
                end
            end
        end else if (!cs_active) begin
            exp_err = 1; m_phase = 0;
        end else if (rx_valid) begin
            if (m_phase == 1) begin
                want = (m_rem <= PKT) ? 3 : (m_first ? 1 : 2);
                if (rx_byte != (8'hF0 | 8'(want))) begin
                    exp_err = 1; m_phase = 0;
                end else begin
                    m_inpkt = (m_rem < PKT) ? int'(m_rem) : PKT;
                    m_first = 0; m_phase = 2;
                end
            end else if (m_phase == 2) begin
                exp_wr = 1; exp_addr = (m_base + m_off) & AMASK; exp_data = rx_byte;
                m_off++; m_rem--; m_inpkt--;
                if (m_inpkt == 0) begin
                    if (m_crc) begin m_skip = 2; m_phase = 3; end
                    else if (m_rem == 0) begin exp_done = 1; m_phase = 0; end
                    else m_phase = 1;
                end
            end else begin
                m_skip--;
                if (m_skip == 0) begin
                    if (m_rem == 0) begin exp_done = 1; m_phase = 0; end
                    else m_phase = 1;
                end
            end
        end
    end

    // Per-cycle comparison and scenario monitors
    logic [7:0] mem [longint];
    int n_wr = 0, n_done = 0, n_err = 0;

    always @(negedge clk) begin
        if (model_live && !finished) begin
            checks++;
            if (wr_en !== exp_wr || (exp_wr && (wr_addr !== AW'(exp_addr) || wr_data !== 8'(exp_data)))) begin
                errors++;
                $display("FAIL R4 write act en=%b a=%h d=%h exp en=%b a=%h d=%h",
                         wr_en, wr_addr, wr_data, exp_wr, AW'(exp_addr), 8'(exp_data));
            end
            checks++;
            if (done !== exp_done) begin
                errors++;
                $display("FAIL R7 done act %b exp %b", done, exp_done);
            end
            checks++;
            if (err !== exp_err) begin
                errors++;
                $display("FAIL R8 err act %b exp %b", err, exp_err);
            end
            if (wr_en === 1'b1) begin mem[longint'(wr_addr)] = wr_data; n_wr++; end
            if (done === 1'b1) n_done++;
            if (err === 1'b1) n_err++;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input bit v, input logic [7:0] b);
        @(negedge clk);
        cmd_start = 1'b0;
        rx_valid = v;
        rx_byte = b;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 8'h00);
    endtask

    task automatic clear_stats();
        quiet(3);
        n_wr = 0; n_done = 0; n_err = 0;
        mem.delete();
    endtask

    task automatic begin_xfer(input longint addr, input int size, input bit crc);
        @(negedge clk);
        rx_valid = 1'b0;
        cmd_start = 1'b1;
        cmd_addr = AW'(addr);
        cmd_size = SW'(size);
        cmd_crc_en = crc;
    endtask

    function automatic logic [7:0] pay(input int seed, input int i);
        return 8'((seed + i * 7) & 8'hFF);
    endfunction

    task automatic send(input logic [7:0] b, input int gap);
        if (gap > 0) quiet(gap);
        tick(1'b1, b);
    endtask

    task automatic stream(input int size, input bit crc, input int seed, input int gap);
        int rem = size;
        int idx = 0;
        bit first = 1;
        while (rem > 0) begin
            int n = (rem < PKT) ? rem : PKT;
            int code = (rem <= PKT) ? 3 : (first ? 1 : 2);
            send(8'hF0 | 8'(code), gap);
            for (int k = 0; k < n; k++) begin
                send(pay(seed, idx), (k % 3 == 1) ? gap : 0);
                idx++;
            end
            if (crc) begin send(8'hA5, gap); send(8'h3C, 0); end
            rem -= n;
            first = 0;
        end
        quiet(3);
    endtask

    function automatic int mem_mismatch(input longint base, input int size, input int seed);
        int bad = 0;
        for (int i = 0; i < size; i++) begin
            longint a = (base + i) & AMASK;
            if (!mem.exists(a) || mem[a] !== pay(seed, i)) bad++;
        end
        return bad;
    endfunction

    task automatic good_xfer(input longint base, input int size, input bit crc, input int seed,
                             input int gap, input string tag);
        clear_stats();
        begin_xfer(base, size, crc);
        stream(size, crc, seed, gap);
        check(n_done == 1, {tag, " done count"}, n_done, 1);
        check(n_err == 0, {tag, " err count"}, n_err, 0);
        check(n_wr == size, {tag, " write count"}, n_wr, size);
        check(mem_mismatch(base, size, seed) == 0, {tag, " memory image"}, mem_mismatch(base, size, seed), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(wr_en == 0 && done == 0 && err == 0, "R1 outputs during reset", {wr_en, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en == 0 && done == 0 && err == 0, "R1 outputs after reset", {wr_en, done, err}, 0);

        // R3 single packet, order 3
        good_xfer(64'h100, 5, 0, 11, 0, "R3 single short packet");
        // R5 three packets 1,2,3 with gaps, R9 gaps
        good_xfer(64'h2000, 20, 0, 3, 2, "R5 R9 three packets gapped");
        // R6 checksum bytes consumed, two packets
        good_xfer(64'h40, 16, 1, 99, 0, "R6 checksum on two packets");
        // R3 exactly one full packet with checksum
        good_xfer(64'h80, PKT, 1, 5, 1, "R3 full single packet");
        // R4 address wrap
        good_xfer(AMASK - 1, 6, 0, 77, 0, "R4 address wrap");

        // R2 short size rejected, R10 new start right after
        clear_stats();
        begin_xfer(64'h300, 4, 0);
        quiet(2);
        check(n_err == 1, "R2 short size err", n_err, 1);
        check(n_wr == 0, "R2 short size no write", n_wr, 0);
        good_xfer(64'h300, 5, 0, 21, 0, "R10 accept after reject");

        // R3 wrong order code for first packet of several
        clear_stats();
        begin_xfer(64'h500, 20, 0);
        send(8'hF3, 0);
        for (int i = 0; i < 6; i++) send(8'h55, 0);
        quiet(2);
        check(n_err == 1, "R3 wrong order err", n_err, 1);
        check(n_wr == 0, "R3 wrong order no write", n_wr, 0);

        // R3 middle packet given as first
        clear_stats();
        begin_xfer(64'h500, 20, 0);
        send(8'hF1, 0);
        for (int i = 0; i < PKT; i++) send(8'h11, 0);
        send(8'hF1, 0);
        quiet(2);
        check(n_err == 1, "R3 middle code err", n_err, 1);
        check(n_wr == PKT, "R3 middle code writes", n_wr, PKT);

        // R3 bad tag nibble
        clear_stats();
        begin_xfer(64'h600, 5, 0);
        send(8'hE3, 0);
        quiet(2);
        check(n_err == 1, "R3 bad tag err", n_err, 1);
        check(n_done == 0, "R3 bad tag no done", n_done, 0);

        // R8 chip select drop mid payload
        clear_stats();
        begin_xfer(64'h700, 20, 0);
        send(8'hF1, 0);
        send(8'h01, 0); send(8'h02, 0); send(8'h03, 0);
        @(negedge clk); rx_valid = 1'b0; cs_active = 1'b0;
        @(negedge clk); cs_active = 1'b1;
        for (int i = 0; i < 5; i++) send(8'h44, 0);
        quiet(2);
        check(n_err == 1, "R8 cs drop err", n_err, 1);
        check(n_wr == 3, "R8 cs drop writes", n_wr, 3);
        check(n_done == 0, "R8 cs drop no done", n_done, 0);

        // R9 start while busy ignored
        clear_stats();
        begin_xfer(64'h900, 10, 0);
        send(8'hF1, 0);
        send(pay(8, 0), 0);
        begin_xfer(64'hA00, 5, 1);
        for (int i = 1; i < PKT; i++) send(pay(8, i), 0);
        send(8'hF3, 0);
        send(pay(8, 8), 0); send(pay(8, 9), 0);
        quiet(3);
        check(n_done == 1, "R9 busy start done", n_done, 1);
        check(mem_mismatch(64'h900, 10, 8) == 0, "R9 busy start image", mem_mismatch(64'h900, 10, 8), 0);
        check(!mem.exists(64'hA00), "R9 busy start address unused", mem.exists(64'hA00), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule